// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one accepted column-access request into the full list of column addresses for a double-rate memory burst. When a request arrives, it records the starting column, a burst-length code and an ordering choice. From the next clock on, it outputs two column addresses per cycle, one for each data word of that cycle's transfer, until the burst is complete.

Only the low bits of the column inside the power-of-two burst window take part in the sequence. Those bits either count upward and wrap inside the window (linear order) or are XORed with the word index (interleaved order). The column bits above the window are never changed. A request that carries a reserved length code starts nothing and raises a one-cycle error pulse. A request that arrives while a burst is running is dropped.

Top module: `burst_colgen`

## Requirements
- R1: Length code 3'b001 on `len_code_i` selects a 2-word burst: exactly one pair is presented, and `last_o` is high on that pair.
- R2: Length code 3'b010 selects a 4-word burst (two pairs), and 3'b011 selects an 8-word burst (four pairs), on consecutive cycles.
- R3: Any other length code (000, 100 to 111) on an accepted-slot request starts no burst. `err_o` is high for exactly the one cycle after that request, and `valid_o` stays low.
- R4: `valid_o` rises the cycle after a request is accepted while idle, and the first word of the first pair equals `start_col_i`.
- R5: With `order_i` = 0 (linear), word i has low bits (start + i) mod L, where L is the burst length.
- R6: With `order_i` = 1 (interleaved), word i has low bits start XOR i inside the log2(L)-bit window.
- R7: Column bits at and above position log2(L) equal those of the start column for every word.
- R8: Pair k carries word 2k on `col_first_o` and word 2k+1 on `col_second_o`.
- R9: `last_o` is high only on the final pair, and `valid_o` is low in the cycle after it.
- R10: A request made while a burst is in progress, including during its final pair, is ignored. The running sequence continues unchanged and no new burst follows.
- R11: During and right after reset, `valid_o`, `last_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst request, sampled on the rising edge |
| start_col_i | input | COL_W | Starting column of the request |
| len_code_i | input | 3 | Burst-length code (001=2, 010=4, 011=8) |
| order_i | input | 1 | 0 = linear wrap, 1 = interleaved |
| valid_o | output | 1 | A column pair is presented this cycle |
| col_first_o | output | COL_W | Column of the earlier word of the pair |
| col_second_o | output | COL_W | Column of the later word of the pair |
| last_o | output | 1 | The present pair ends the burst |
| err_o | output | 1 | Previous cycle's request carried a reserved code |

## Verification
The hardest case to reach is a request that arrives in the final cycle of a burst. At that point the block is still busy, but it goes idle at the very edge that samples the request. The bench keeps a request asserted across the last pair of an 8-word burst, and in a separate test across a middle pair. It then checks that the column sequence does not change and that `valid_o` drops after the last pair. Wrap cases use start columns near the top of a window and at the top of the column range, so that a carry out of the window would change the upper bits if it were not masked.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

   localparam int unsigned MAX_LEN_LOG2 = 3;
   localparam int unsigned PAIR_W       = MAX_LEN_LOG2 - 1;

   typedef enum logic {
      ORDER_LINEAR = 1'b0,
      ORDER_XOR    = 1'b1
   } order_e;

   typedef struct packed {
      logic       ok;
      logic [1:0] len_log2;
   } len_dec_t;

   function automatic logic [MAX_LEN_LOG2-1:0] window_mask(input logic [1:0] len_log2);
      case (len_log2)
         2'd1:    return 3'b001;
         2'd2:    return 3'b011;
         2'd3:    return 3'b111;
         default: return 3'b000;
      endcase
   endfunction

   function automatic logic [PAIR_W-1:0] last_pair(input logic [1:0] len_log2);
      case (len_log2)
         2'd2:    return 2'd1;
         2'd3:    return 2'd3;
         default: return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_colgen_pkg::*;
(
   input  logic [2:0] code_i,
   output len_dec_t   dec_o
);

   always_comb begin
      dec_o = '0;
      case (code_i)
         3'b001:  begin dec_o.ok = 1'b1; dec_o.len_log2 = 2'd1; end
         3'b010:  begin dec_o.ok = 1'b1; dec_o.len_log2 = 2'd2; end
         3'b011:  begin dec_o.ok = 1'b1; dec_o.len_log2 = 2'd3; end
         default: dec_o = '0;
      endcase
   end

endmodule

// File: rtl/burst_lane_addr.sv
module burst_lane_addr
   import burst_colgen_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic [COL_W-1:0]        base_i,
   input  logic [MAX_LEN_LOG2-1:0] mask_i,
   input  order_e                  order_i,
   input  logic [MAX_LEN_LOG2-1:0] idx_i,
   output logic [COL_W-1:0]        col_o
);

   localparam int unsigned IW = MAX_LEN_LOG2;

   logic [IW-1:0] base_lo;
   logic [IW-1:0] lin_lo;
   logic [IW-1:0] xor_lo;
   logic [IW-1:0] pick_lo;

   always_comb begin
      base_lo = base_i[IW-1:0];
      lin_lo  = base_lo + idx_i;
      xor_lo  = base_lo ^ idx_i;
      pick_lo = (order_i == ORDER_XOR) ? xor_lo : lin_lo;
      col_o          = base_i;
      col_o[IW-1:0]  = (base_lo & ~mask_i) | (pick_lo & mask_i);
   end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
   import burst_colgen_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [PAIR_W-1:0] lim_i,
   output logic              active_o,
   output logic [PAIR_W-1:0] pair_o,
   output logic              last_o
);

   logic              active_q;
   logic [PAIR_W-1:0] cnt_q;
   logic [PAIR_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         lim_q    <= '0;
      end else if (go_i) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         lim_q    <= lim_i;
      end else if (active_q) begin
         if (cnt_q == lim_q) active_q <= 1'b0;
         else                cnt_q    <= cnt_q + 1'b1;
      end
   end

   assign active_o = active_q;
   assign pair_o   = cnt_q;
   assign last_o   = active_q && (cnt_q == lim_q);

   // R9: burst ends right after its final pair
   assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !go_i) |=> !active_o);

   // R2: pairs advance one per cycle without gaps
   assert_pair_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !last_o) |=> (active_o && pair_o == $past(pair_o) + 1'b1));

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
   import burst_colgen_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_code_i,
   input  logic             order_i,
   output logic             valid_o,
   output logic [COL_W-1:0] col_first_o,
   output logic [COL_W-1:0] col_second_o,
   output logic             last_o,
   output logic             err_o
);

   localparam int unsigned NLANE = 2;
   localparam int unsigned HI_W  = COL_W - MAX_LEN_LOG2;

   if (COL_W <= MAX_LEN_LOG2) begin : g_bad_width
      $error("COL_W must exceed the largest burst window width");
   end

   len_dec_t          dec;
   logic              active;
   logic              seq_last;
   logic [PAIR_W-1:0] pair_idx;
   logic              accept;
   logic [COL_W-1:0]  base_q;
   logic [MAX_LEN_LOG2-1:0] mask_q;
   order_e            order_q;
   logic              err_q;
   logic [COL_W-1:0]  lane_col [NLANE];
   logic [COL_W-1:0]  keep_mask;

   burst_len_decode u_dec (
      .code_i (len_code_i),
      .dec_o  (dec)
   );

   assign accept = start_i && !active && dec.ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         mask_q  <= '0;
         order_q <= ORDER_LINEAR;
         err_q   <= 1'b0;
      end else begin
         err_q <= start_i && !active && !dec.ok;
         if (accept) begin
            base_q  <= start_col_i;
            mask_q  <= window_mask(dec.len_log2);
            order_q <= order_e'(order_i);
         end
      end
   end

   burst_seq_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (accept),
      .lim_i    (last_pair(dec.len_log2)),
      .active_o (active),
      .pair_o   (pair_idx),
      .last_o   (seq_last)
   );

   for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
      burst_lane_addr #(.COL_W(COL_W)) u_lane (
         .base_i  (base_q),
         .mask_i  (mask_q),
         .order_i (order_q),
         .idx_i   ({pair_idx, 1'(ln)}),
         .col_o   (lane_col[ln])
      );
   end

   assign valid_o      = active;
   assign last_o       = seq_last;
   assign err_o        = err_q;
   assign col_first_o  = lane_col[0];
   assign col_second_o = lane_col[1];
   assign keep_mask    = {{HI_W{1'b1}}, ~mask_q};

   // R3: reserved code gives an error pulse and no burst
   assert_reserved_no_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !active && !dec.ok) |=> (err_o && !valid_o));

   // R4: burst opens on the requested column
   assert_first_is_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (valid_o && col_first_o == $past(start_col_i)));

   // R5: in linear order the second word follows the first inside the window
   assert_linear_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && order_q == ORDER_LINEAR) |->
         (((col_second_o - col_first_o) & {{HI_W{1'b0}}, mask_q}) == COL_W'(1)));

   // R6: in interleaved order the pair differs in bit 0 only
   assert_xor_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && order_q == ORDER_XOR) |-> ((col_first_o ^ col_second_o) == COL_W'(1)));

   // R7: bits outside the window never move
   assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (((col_first_o ^ base_q) & keep_mask) == '0 &&
                   ((col_second_o ^ base_q) & keep_mask) == '0));

   // R10: a request during a burst leaves it untouched
   assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && start_i) |=> ($stable(base_q) && $stable(mask_q) && !err_o));

   // R11: nothing is presented while in reset
   always_comb begin
      if (!rst_n) assert_reset_quiet_R11: assert (!valid_o && !last_o && !err_o);
   end

endmodule

// File: tb/burst_colgen_bench.sv
module burst_colgen_bench;

   localparam int unsigned COL_W = 10;

   // {len code, order, start column, pair count}
   localparam int NV = 8;
   localparam logic [16:0] VEC [NV] = '{
      {3'b001, 1'b0, 10'h005, 3'd1},
      {3'b010, 1'b0, 10'h00E, 3'd2},
      {3'b011, 1'b0, 10'h3FD, 3'd4},
      {3'b011, 1'b1, 10'h0A5, 3'd4},
      {3'b010, 1'b1, 10'h013, 3'd2},
      {3'b001, 1'b1, 10'h200, 3'd1},
      {3'b011, 1'b0, 10'h127, 3'd4},
      {3'b011, 1'b1, 10'h3FF, 3'd4}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       len_code_i = 3'b001;
   logic             order_i = 1'b0;
   logic             valid_o, last_o, err_o;
   logic [COL_W-1:0] col_first_o, col_second_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   burst_colgen #(.COL_W(COL_W)) u_burst_colgen (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .start_col_i  (start_col_i),
      .len_code_i   (len_code_i),
      .order_i      (order_i),
      .valid_o      (valid_o),
      .col_first_o  (col_first_o),
      .col_second_o (col_second_o),
      .last_o       (last_o),
      .err_o        (err_o)
   );

   function automatic logic [COL_W-1:0] model_col(input logic [COL_W-1:0] st,
      input logic [2:0] code, input logic ord, input int idx);
      logic [COL_W-1:0] m, lo;
      m  = (COL_W'(1) << code) - 1'b1;
      lo = ord ? (st ^ COL_W'(idx)) : (st + COL_W'(idx));
      return (st & ~m) | (lo & m);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // request at a falling edge, then check each pair at later falling edges
   task automatic run_burst(input logic [2:0] code, input logic ord,
      input logic [COL_W-1:0] st, input int npairs, input int hold_from);
      start_col_i = st; len_code_i = code; order_i = ord; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < npairs; k++) begin
         if (k == hold_from) begin
            start_i = 1'b1; start_col_i = ~st; order_i = ~ord;
         end
         check("R4/R8 valid", valid_o, 1);
         check("R5/R6/R7/R8 first", col_first_o, model_col(st, code, ord, 2*k));
         check("R5/R6/R7/R8 second", col_second_o, model_col(st, code, ord, 2*k+1));
         check("R1/R2/R9 last", last_o, (k == npairs-1));
         @(negedge clk);
      end
      start_i = 1'b0;
      check("R9/R10 idle after burst", valid_o, 0);
      check("R10 no error", err_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R11 valid in reset", valid_o, 0);
      check("R11 last in reset", last_o, 0);
      check("R11 err in reset", err_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 valid after reset", valid_o, 0);

      for (int v = 0; v < NV; v++) begin
         run_burst(VEC[v][16:14], VEC[v][13], VEC[v][12:3], int'(VEC[v][2:0]), 99);
         @(negedge clk);
      end

      // R3: every reserved code
      for (int c = 0; c < 8; c++) begin
         if (c >= 1 && c <= 3) continue;
         len_code_i = 3'(c); start_col_i = 10'h055; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         check("R3 err pulse", err_o, 1);
         check("R3 no burst", valid_o, 0);
         @(negedge clk);
         check("R3 err one cycle", err_o, 0);
         check("R3 still idle", valid_o, 0);
      end

      // R10: request held over a middle pair, then over the final pair
      run_burst(3'b011, 1'b0, 10'h0F6, 4, 1);
      @(negedge clk);
      run_burst(3'b011, 1'b1, 10'h2C3, 4, 3);
      @(negedge clk);
      check("R10 no burst after ignored request", valid_o, 0);

      // R2: back-to-back request right after idle is accepted
      run_burst(3'b010, 1'b0, 10'h3FF, 2, 99);
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule